// File: doc/BRIEF.md
# Phase-Change Array Access Sequencer

This block sequences every access to a one-transistor, one-resistor phase-change memory array of 256 rows by 256 columns. The columns are split into 16 groups of 16. Each group feeds one sense channel, and a 4-bit column index picks one column inside every group at once. A request carries a 12-bit address, a write/read flag, a single-ended or differential mode flag and 16 bits of write data. It is accepted on a valid/ready handshake.

A write turns on the write driver of the selected column in each group. The data bit picks the drive level for that column. A SET (crystallising) drive is held longer than a RESET (melt) drive. Once the programming pulse ends, the columns are discharged. A read first precharges the selected columns, waits for the sense outputs to settle, captures them into a data register and pulses a valid flag. A read never writes back.

In single-ended mode a word is 16 bits, one per group. In differential mode a word is 8 bits. Data bit k is stored true in group 2k and complemented in group 2k+1. On a read, a pair that is not complementary raises a sticky error flag.

Top module: `pcm_seq`

## Requirements
- R1: The address splits as bits [11:8] = column index within each group and bits [7:0] = row. While an access is active, `row_sel` is one-hot at the row during the write pulse, sense and capture phases. `col_sel` is one-hot at the column index during precharge, sense and capture. Both are all zero in idle.
- R2: During a write pulse, the only write enables that can be high are those of columns g*16+index (g = 0..15). Every other driver stays off.
- R3: A write data bit of 1 drives its column at the SET level (`wr_lvl` = 1). A data bit of 0 drives it at the RESET level (`wr_lvl` = 0).
- R4: The write enable of a SET column stays high for exactly T_SET cycles. That of a RESET column stays high for exactly T_RESET cycles, where T_SET > T_RESET. A word with no SET bit ends its pulse after T_RESET cycles.
- R5: Every write pulse is followed directly by `dis_en` high for exactly T_DIS cycles. `dis_en` and `pre_en` are never high together.
- R6: Every read starts with `pre_en` high for exactly T_PRE cycles, with `col_sel` already valid. Sensing of the row then follows.
- R7: In single-ended mode, `rd_data[g]` holds the value sensed on group g. `rd_valid` is high for exactly one cycle per read.
- R8: In differential mode, write data bit k drives group 2k with bit k and group 2k+1 with its complement.
- R9: In differential mode, `rd_data[k]` is the value sensed on group 2k and `rd_data[15:8]` is zero. A read in which any pair senses equal values sets `pair_err`, which stays set until reset.
- R10: `req_ready` is high only when no access is in progress. During a read, no write enable is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_diff | input | 1 | 1 = differential (8-bit word), 0 = single-ended (16-bit word) |
| req_addr | input | 12 | [11:8] column within group, [7:0] row |
| req_wdata | input | 16 | Write data (low 8 bits used in differential mode) |
| sense_in | input | 16 | Sense channel outputs, one per column group |
| row_sel | output | 256 | One-hot row select |
| col_sel | output | 16 | One-hot read column select within each group |
| wr_en | output | 256 | Per-column write driver enable |
| wr_lvl | output | 256 | Per-column drive level, 1 = SET, 0 = RESET |
| pre_en | output | 1 | Precharge selected columns |
| dis_en | output | 1 | Discharge columns after a write |
| rd_data | output | 16 | Captured read word |
| rd_valid | output | 1 | One-cycle read completion pulse |
| pair_err | output | 1 | Sticky differential pair mismatch |

## Verification
A single write whose data mixes ones and zeros applies SET and RESET drives in the same cycles. The RESET columns must drop out after T_RESET while the SET columns carry on to T_SET. The bench writes such words in both modes and counts, column by column, how many cycles each enable is high. It checks that these counts match the length for that column's level, and that no column outside the selected index is ever enabled. The values are then read back through a behavioural array, which confirms that each level reached the intended cell.

// File: rtl/pcm_pkg.sv
package pcm_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_SENSE = 3'd2,
      ST_CAPT  = 3'd3,
      ST_PULSE = 3'd4,
      ST_DIS   = 3'd5
   } seq_state_t;
endpackage

// File: rtl/pcm_addr_decode.sv
module pcm_addr_decode #(
   parameter int ROWS  = 256,
   parameter int GSIZE = 16,
   localparam int ROW_W = $clog2(ROWS),
   localparam int CSL_W = $clog2(GSIZE)
) (
   input  logic               row_on,
   input  logic               col_on,
   input  logic [ROW_W-1:0]   row_idx,
   input  logic [CSL_W-1:0]   col_idx,
   output logic [ROWS-1:0]    row_sel,
   output logic [GSIZE-1:0]   col_sel
);
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign row_sel[r] = row_on && (row_idx == ROW_W'(r));
   end
   for (genvar k = 0; k < GSIZE; k++) begin : g_col
      assign col_sel[k] = col_on && (col_idx == CSL_W'(k));
   end
endmodule

// File: rtl/pcm_timer.sv
module pcm_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] len,
   output logic [CNT_W-1:0] cnt,
   output logic             done
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt + 1'b1;
   end
   assign done = (cnt == len - 1'b1);
endmodule

// File: rtl/pcm_wdrive.sv
module pcm_wdrive #(
   parameter int GROUPS  = 16,
   parameter int GSIZE   = 16,
   parameter int T_RESET = 3,
   parameter int CNT_W   = 4,
   localparam int COLS  = GROUPS * GSIZE,
   localparam int CSL_W = $clog2(GSIZE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              diff,
   input  logic [CSL_W-1:0]  col_idx,
   input  logic [GROUPS-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   output logic              any_set,
   output logic [COLS-1:0]   wr_en,
   output logic [COLS-1:0]   wr_lvl
);
   logic [GROUPS-1:0] lvl;

   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      if (g % 2 == 0) begin : g_true
         assign lvl[g] = diff ? wdata[g/2] : wdata[g];
      end else begin : g_comp
         assign lvl[g] = diff ? ~wdata[g/2] : wdata[g];
      end
      for (genvar k = 0; k < GSIZE; k++) begin : g_col
         logic hit;
         assign hit = active && (col_idx == CSL_W'(k))
                      && (lvl[g] || (cnt < CNT_W'(T_RESET)));
         assign wr_en[g*GSIZE+k]  = hit;
         assign wr_lvl[g*GSIZE+k] = hit && lvl[g];
      end
   end
   assign any_set = |lvl;

   AST_ONE_PER_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(wr_en) <= GROUPS);                                  // R2
   AST_LVL_ONLY_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lvl & ~wr_en) == '0);                                      // R3
endmodule

// File: rtl/pcm_readcap.sv
module pcm_readcap #(
   parameter int GROUPS = 16,
   localparam int HALF = GROUPS / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic              diff,
   input  logic [GROUPS-1:0] sense,
   output logic [GROUPS-1:0] rd_data,
   output logic              rd_valid,
   output logic              pair_err
);
   logic [HALF-1:0] dval, mism;

   for (genvar j = 0; j < HALF; j++) begin : g_pair
      assign dval[j] = sense[2*j];
      assign mism[j] = (sense[2*j] == sense[2*j+1]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
         pair_err <= 1'b0;
      end else begin
         rd_valid <= cap;
         if (cap) begin
            rd_data <= diff ? {{(GROUPS-HALF){1'b0}}, dval} : sense;
            if (diff && |mism) pair_err <= 1'b1;
         end
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);                                       // R7
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      pair_err |=> pair_err);                                        // R9
endmodule

// File: rtl/pcm_seq.sv
module pcm_seq
   import pcm_pkg::*;
#(
   parameter int ROWS      = 256,
   parameter int GROUPS    = 16,
   parameter int GSIZE     = 16,
   parameter int T_RESET   = 3,
   parameter int T_SET     = 8,
   parameter int T_PRE     = 2,
   parameter int T_SENSE   = 3,
   parameter int T_DIS     = 2,
   parameter int BUDGET    = 40,
   localparam int ROW_W   = $clog2(ROWS),
   localparam int CSL_W   = $clog2(GSIZE),
   localparam int ADDR_W  = ROW_W + CSL_W,
   localparam int COLS    = GROUPS * GSIZE,
   localparam int MAX_A   = (T_SET > T_PRE) ? T_SET : T_PRE,
   localparam int MAX_B   = (T_SENSE > T_DIS) ? T_SENSE : T_DIS,
   localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B,
   localparam int CNT_W   = $clog2(MAX_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic              req_diff,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [GROUPS-1:0] req_wdata,
   input  logic [GROUPS-1:0] sense_in,
   output logic [ROWS-1:0]   row_sel,
   output logic [GSIZE-1:0]  col_sel,
   output logic [COLS-1:0]   wr_en,
   output logic [COLS-1:0]   wr_lvl,
   output logic              pre_en,
   output logic              dis_en,
   output logic [GROUPS-1:0] rd_data,
   output logic              rd_valid,
   output logic              pair_err
);
   if (T_SET <= T_RESET) begin : g_bad_pulse
      $error("SET pulse must be longer than RESET pulse");
   end
   if (T_SET > BUDGET) begin : g_bad_budget
      $error("SET pulse exceeds programming budget");
   end
   if (T_RESET < 1 || T_PRE < 1 || T_SENSE < 1 || T_DIS < 1) begin : g_bad_len
      $error("phase lengths must be at least one cycle");
   end
   if (GROUPS % 2 != 0) begin : g_bad_groups
      $error("differential mode needs an even group count");
   end

   seq_state_t        state, nxt;
   logic [ADDR_W-1:0] addr_q;
   logic [GROUPS-1:0] wdata_q;
   logic              diff_q, write_q;
   logic              take, done, any_set;
   logic [CNT_W-1:0]  cnt, len;

   assign req_ready = (state == ST_IDLE);
   assign take      = req_valid && req_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         diff_q  <= 1'b0;
         write_q <= 1'b0;
      end else if (take) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
         diff_q  <= req_diff;
         write_q <= req_write;
      end
   end

   always_comb begin
      unique case (state)
         ST_PRE:   len = CNT_W'(T_PRE);
         ST_SENSE: len = CNT_W'(T_SENSE);
         ST_PULSE: len = any_set ? CNT_W'(T_SET) : CNT_W'(T_RESET);
         ST_DIS:   len = CNT_W'(T_DIS);
         default:  len = CNT_W'(1);
      endcase
   end

   always_comb begin
      nxt = state;
      unique case (state)
         ST_IDLE:  if (take) nxt = req_write ? ST_PULSE : ST_PRE;
         ST_PRE:   if (done) nxt = ST_SENSE;
         ST_SENSE: if (done) nxt = ST_CAPT;
         ST_CAPT:  nxt = ST_IDLE;
         ST_PULSE: if (done) nxt = ST_DIS;
         ST_DIS:   if (done) nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   pcm_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n),
      .clr(state == ST_IDLE || nxt != state),
      .len(len), .cnt(cnt), .done(done)
   );

   pcm_addr_decode #(.ROWS(ROWS), .GSIZE(GSIZE)) u_dec (
      .row_on(state == ST_SENSE || state == ST_CAPT || state == ST_PULSE),
      .col_on(state == ST_PRE || state == ST_SENSE || state == ST_CAPT),
      .row_idx(addr_q[ROW_W-1:0]),
      .col_idx(addr_q[ADDR_W-1:ROW_W]),
      .row_sel(row_sel), .col_sel(col_sel)
   );

   pcm_wdrive #(.GROUPS(GROUPS), .GSIZE(GSIZE), .T_RESET(T_RESET),
                .CNT_W(CNT_W)) u_drv (
      .clk(clk), .rst_n(rst_n),
      .active(state == ST_PULSE), .diff(diff_q),
      .col_idx(addr_q[ADDR_W-1:ROW_W]), .wdata(wdata_q), .cnt(cnt),
      .any_set(any_set), .wr_en(wr_en), .wr_lvl(wr_lvl)
   );

   pcm_readcap #(.GROUPS(GROUPS)) u_cap (
      .clk(clk), .rst_n(rst_n),
      .cap(state == ST_CAPT), .diff(diff_q), .sense(sense_in),
      .rd_data(rd_data), .rd_valid(rd_valid), .pair_err(pair_err)
   );

   assign pre_en = (state == ST_PRE);
   assign dis_en = (state == ST_DIS);

   AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(row_sel) && $onehot0(col_sel));                       // R1
   AST_PRE_DIS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(pre_en && dis_en));                                          // R5
   AST_DIS_FOLLOWS_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dis_en) |-> $past(wr_en != '0));                         // R5
   AST_NO_WR_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en || col_sel != '0) |-> (wr_en == '0));                  // R10
   AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_en || dis_en || wr_en != '0) |-> !req_ready);             // R10
   AST_PRE_BEFORE_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pre_en) |-> (row_sel != '0));                            // R6
endmodule

// File: tb/pcm_seq_bench.sv
module pcm_seq_bench;
   localparam int TR = 3, TS = 8, TP = 2, TN = 3, TD = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0, req_write = 1'b0, req_diff = 1'b0;
   logic [11:0]  req_addr = '0;
   logic [15:0]  req_wdata = '0;
   logic [15:0]  sense_in;
   logic         req_ready, pre_en, dis_en, rd_valid, pair_err;
   logic [255:0] row_sel, wr_en, wr_lvl;
   logic [15:0]  col_sel, rd_data;
   logic [15:0]  inj = '0;
   logic [255:0] mem [256];

   int total = 0, bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   pcm_seq #(.T_RESET(TR), .T_SET(TS), .T_PRE(TP), .T_SENSE(TN),
             .T_DIS(TD)) u_pcm_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_diff(req_diff), .req_addr(req_addr),
      .req_wdata(req_wdata), .sense_in(sense_in), .row_sel(row_sel),
      .col_sel(col_sel), .wr_en(wr_en), .wr_lvl(wr_lvl), .pre_en(pre_en),
      .dis_en(dis_en), .rd_data(rd_data), .rd_valid(rd_valid),
      .pair_err(pair_err)
   );

   // behavioural array: cells take the drive level while enabled
   int cur_row, cur_col;
   always_comb begin
      cur_row = -1;
      cur_col = -1;
      for (int r = 0; r < 256; r++) if (row_sel[r]) cur_row = r;
      for (int k = 0; k < 16; k++) if (col_sel[k]) cur_col = k;
      sense_in = '0;
      if (cur_row >= 0 && cur_col >= 0)
         for (int g = 0; g < 16; g++)
            sense_in[g] = mem[cur_row][g*16+cur_col] ^ inj[g];
   end

   always @(negedge clk)
      if (cur_row >= 0)
         for (int c = 0; c < 256; c++)
            if (wr_en[c]) mem[cur_row][c] = wr_lvl[c];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic issue(input bit wr, input bit df, input logic [11:0] a,
                        input logic [15:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_diff = df;
      req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // write with per-column enable counting; starts sampling in first pulse cycle
   task automatic t_write(input bit df, input logic [11:0] a,
                          input logic [15:0] d);
      int en_cnt [256];
      int dis_cyc = 0, pulse_cyc = 0, busy_rdy = 0, lvl_bad = 0, row_bad = 0;
      int guard = 0;
      bit lvl [16];
      int k = int'(a[11:8]);
      bit any1 = 0;
      for (int c = 0; c < 256; c++) en_cnt[c] = 0;
      for (int g = 0; g < 16; g++) begin
         lvl[g] = df ? ((g % 2 == 0) ? d[g/2] : ~d[g/2]) : d[g];
         any1 |= lvl[g];
      end
      issue(1'b1, df, a, d);
      while (!req_ready && guard < 200) begin
         guard++;
         if (wr_en != '0) begin
            pulse_cyc++;
            if (row_sel != (256'd1 << a[7:0])) row_bad++;
         end
         if (dis_en) dis_cyc++;
         if (dis_en && wr_en != '0) lvl_bad++;
         for (int c = 0; c < 256; c++) if (wr_en[c]) begin
            en_cnt[c]++;
            if (wr_lvl[c] != lvl[c/16]) lvl_bad++;
         end
         @(negedge clk);
      end
      begin
         int stray = 0, len_bad = 0;
         for (int c = 0; c < 256; c++) begin
            if ((c % 16) != k && en_cnt[c] != 0) stray++;
            if ((c % 16) == k && en_cnt[c] != (lvl[c/16] ? TS : TR)) len_bad++;
         end
         check(stray == 0, "R2", "columns outside index enabled", stray, 0);
         check(len_bad == 0, "R4", "per-column pulse length mismatches", len_bad, 0);
         check(lvl_bad == 0, "R3", "drive level mismatches", lvl_bad, 0);
         check(row_bad == 0, "R1", "row select during pulse", row_bad, 0);
         check(pulse_cyc == (any1 ? TS : TR), "R4", "pulse cycles",
               pulse_cyc, any1 ? TS : TR);
         check(dis_cyc == TD, "R5", "discharge cycles", dis_cyc, TD);
         check(guard == (any1 ? TS : TR) + TD, "R10", "busy cycles before ready",
               guard, (any1 ? TS : TR) + TD);
      end
      if (df) begin
         int cbad = 0;
         for (int j = 0; j < 8; j++)
            if (mem[a[7:0]][(2*j)*16+k] != d[j] ||
                mem[a[7:0]][(2*j+1)*16+k] != ~d[j]) cbad++;
         check(cbad == 0, "R8", "complement pairs in array", cbad, 0);
      end
   endtask

   task automatic t_read(input bit df, input logic [11:0] a,
                         input logic [15:0] exp);
      int pre_cyc = 0, wr_seen = 0, col_bad = 0, sense_cyc = 0, guard = 0;
      bit pre_before = 1;
      issue(1'b0, df, a, 16'h0);
      while (!rd_valid && guard < 200) begin
         guard++;
         if (pre_en) begin
            pre_cyc++;
            if (col_sel != (16'd1 << a[11:8])) col_bad++;
            if (sense_cyc != 0) pre_before = 0;
         end
         if (row_sel == (256'd1 << a[7:0])) sense_cyc++;
         if (wr_en != '0) wr_seen++;
         @(negedge clk);
      end
      check(pre_cyc == TP, "R6", "precharge cycles", pre_cyc, TP);
      check(pre_before && col_bad == 0, "R6", "precharge order/col_sel",
            col_bad, 0);
      check(sense_cyc == TN + 1, "R1", "row select during sense+capture",
            sense_cyc, TN + 1);
      check(wr_seen == 0, "R10", "write enable during read", wr_seen, 0);
      check(rd_valid && rd_data == exp, df ? "R9" : "R7", "read data",
            rd_data, exp);
      @(negedge clk);
      check(!rd_valid && req_ready, "R7", "valid single pulse", rd_valid, 0);
   endtask

   initial begin
      for (int r = 0; r < 256; r++) mem[r] = '0;
      repeat (3) @(negedge clk);
      check(req_ready && row_sel == '0 && col_sel == '0 && wr_en == '0 &&
            !rd_valid && !pair_err && !pre_en && !dis_en, "R10",
            "reset state", {req_ready, pair_err}, 2'b10);
      rst_n = 1'b1;
      // single-ended mixed word
      t_write(1'b0, 12'h3A5, 16'hA5C3);
      t_read (1'b0, 12'h3A5, 16'hA5C3);
      // all ones then all zeros at another cell, boundary indices
      t_write(1'b0, 12'hFFF, 16'hFFFF);
      t_read (1'b0, 12'hFFF, 16'hFFFF);
      t_write(1'b0, 12'h000, 16'h0000);
      t_read (1'b0, 12'h000, 16'h0000);
      // overwrite ones with zeros: RESET-only pulse
      t_write(1'b0, 12'hFFF, 16'h0000);
      t_read (1'b0, 12'hFFF, 16'h0000);
      // neighbouring column index untouched by previous writes
      t_write(1'b0, 12'h4A5, 16'h1234);
      t_read (1'b0, 12'h3A5, 16'hA5C3);
      // differential mode
      t_write(1'b1, 12'h710, 16'h005A);
      t_read (1'b1, 12'h710, 16'h005A);
      check(!pair_err, "R9", "no pair error on clean read", pair_err, 0);
      t_write(1'b1, 12'h811, 16'h00FF);
      t_read (1'b1, 12'h811, 16'h00FF);
      // corrupt the complement of pair 0: sense 1 equals sense 0
      inj = 16'h0002;
      t_read (1'b1, 12'h710, 16'h005A);
      check(pair_err, "R9", "pair error raised", pair_err, 1);
      inj = 16'h0000;
      t_read (1'b1, 12'h710, 16'h005A);
      check(pair_err, "R9", "pair error sticky", pair_err, 1);
      // single-ended read of a differential word shows raw pairs
      t_read (1'b0, 12'h811, 16'h5555);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog run did not complete actual=0 expected=1");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule